// File: doc/BRIEF.md
# Calibration Trim-DAC Serial Loader

This block programs a bank of three chained 8-channel, 8-bit trim converters used for offset and gain calibration. A request names a flat trim index and an 8-bit trim value. The block builds an 11-bit serial word and clocks it out one bit at a time on a data line and a shift clock. It then drives a 2-bit load code that tells one of the three converters to latch the word. The block keeps a readback copy of the last value it loaded into each index, and a separate combinational port reads that copy.

Requests enter on a valid/ready handshake. A transfer takes place on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. After a legal index is accepted, `req_ready` stays low until the load code has returned to zero. A sender that holds `req_valid` high during that time keeps its request waiting. The sender may change the payload while `req_ready` is low, and only the payload present at the accepting edge is used. An illegal index is accepted and discarded in one cycle and raises a one-cycle error flag.

The shift clock's half-period is set by a divider input. Its value is captured when a request is accepted, so a change during a frame has no effect on that frame.

Top module: `trim_loader`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A legal request accepted at edge E keeps `req_ready` low for 23*(H) cycles, where H = `half_period`+1 taken at E. `req_ready` is high again in the following cycle. A request held on the inputs during that time is accepted only once `req_ready` returns high.
- R2: The serial word has 11 bits and is sent most significant bit first. Bits 10..8 are `req_index[2:0]`, the channel inside one converter. Bits 7..0 are `req_value[7:0]`.
- R3: For each bit, `ser_data` is driven while `ser_clk` is low, and `ser_clk` then rises. `ser_data` does not change while `ser_clk` is high, so the receiver samples it on the rising edge.
- R4: Every low phase and every high phase of `ser_clk` lasts H cycles. A change to `half_period` after acceptance does not alter the frame in progress.
- R5: After the 11th high phase, `load_code` equals (`req_index` >> 3) + 1 for H cycles, with `ser_clk` and `ser_data` low. This gives 1 for indices 0..7, 2 for 8..15 and 3 for 16..20. `load_code` then returns to 0, which means no load.
- R6: `load_code` is 0 at all times except in that load window. In particular it is 0 whenever `ser_clk` is high.
- R7: A request with `req_index` above 20 produces no serial activity and no load code. It raises `err_flag` for exactly the one cycle after the accepting edge and leaves every readback entry unchanged. `req_ready` stays high.
- R8: The readback entry for an index takes the new value only when `load_code` returns to 0. During the load window it still shows the previous value.
- R9: `rb_value` combinationally shows the readback entry selected by `rb_index`. For `rb_index` above 20 it reads 0.
- R10: While `rst_n` is low, and right after it is released, `req_ready` is 1. `ser_clk`, `ser_data`, `load_code` and `err_flag` are 0, and all 21 readback entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| half_period | input | 8 | Shift clock half-period minus one, in clock cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_index | input | 5 | Flat trim index, legal range 0..20 |
| req_value | input | 8 | Trim value |
| ser_data | output | 1 | Serial data to the trim converters |
| ser_clk | output | 1 | Serial shift clock, data sampled on its rising edge |
| load_code | output | 2 | Converter latch select, 0 = none, 1..3 = converter 0..2 |
| err_flag | output | 1 | One-cycle pulse after an out-of-range index is accepted |
| rb_index | input | 5 | Readback entry select |
| rb_value | output | 8 | Last value loaded at `rb_index` |

## Verification
A fault in the shift register or bit counter shows as a wrong 11-bit word, or a wrong number of rising shift clock edges, by the end of that frame. A fault in the divider or phase state changes the busy length of 23*H cycles, or moves `ser_data` while the clock is high, within one half-period. A fault in the load state shows as a wrong or mistimed load code. A fault in the readback store appears on the next `rb_value` read, either as a value that changes during the load window or as an entry touched by a rejected request.

// File: rtl/trim_pkg.sv
`timescale 1ns/1ps
package trim_pkg;
  // channels served by one trim converter and the index bits that select them
  localparam int CH_PER_CONV = 8;
  localparam int CH_BITS     = 3;
  // width of one trim value
  localparam int TRIM_W      = 8;
  // serial word: channel bits above the value bits
  localparam int WORD_W      = CH_BITS + TRIM_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } loader_state_t;
endpackage

// File: rtl/trim_divider.sv
`timescale 1ns/1ps
// Counts clock cycles while run is high and pulses tick every limit+1 cycles.
module trim_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4: while running, the count never passes the latched half-period
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/trim_shifter.sv
`timescale 1ns/1ps
// Sends one word MSB first, with a low phase and then a high phase per bit.
module trim_shifter #(
  parameter int WORD_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              tick,
  output logic              sdata,
  output logic              sclk,
  output logic              done
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              active_q;
  logic              high_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] sreg_q;

  assign sdata = active_q & sreg_q[WORD_W-1];
  assign sclk  = active_q & high_q;
  assign done  = active_q && tick && high_q && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
      left_q   <= '0;
      sreg_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      high_q   <= 1'b0;
      left_q   <= CNT_W'(WORD_W - 1);
      sreg_q   <= word_in;
    end else if (active_q && tick) begin
      if (!high_q) begin
        high_q <= 1'b1;
      end else if (left_q == '0) begin
        active_q <= 1'b0;
        high_q   <= 1'b0;
      end else begin
        high_q <= 1'b0;
        left_q <= left_q - 1'b1;
        sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  // R3: data is held steady for the whole high phase
  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> (sdata == $past(sdata)));

  // R4: the shift clock only changes level on a divider tick or a start
  assert_phase_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));
endmodule

// File: rtl/trim_store.sv
`timescale 1ns/1ps
// Readback copy of the last value loaded at each trim index.
module trim_store #(
  parameter int NUM_IDX = 21,
  parameter int IDX_W   = 5,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] entry_q [NUM_IDX];

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                                entry_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))   entry_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_IDX; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = entry_q[i];
    end
  end

  // R8: writes only ever target a legal index
  assert_write_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_IDX)));
endmodule

// File: rtl/trim_loader.sv
`timescale 1ns/1ps
module trim_loader
  import trim_pkg::*;
#(
  parameter int AO_CHANNELS = 10,
  parameter int DIV_W       = 8,
  parameter int NUM_IDX     = 2 * AO_CHANNELS + 1,
  parameter int IDX_W       = $clog2(NUM_IDX),
  parameter int NUM_CONV    = (NUM_IDX + CH_PER_CONV - 1) / CH_PER_CONV,
  parameter int CODE_W      = $clog2(NUM_CONV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [TRIM_W-1:0] req_value,
  output logic              ser_data,
  output logic              ser_clk,
  output logic [CODE_W-1:0] load_code,
  output logic              err_flag,
  input  logic [IDX_W-1:0]  rb_index,
  output logic [TRIM_W-1:0] rb_value
);
  loader_state_t     state_q;
  logic [DIV_W-1:0]  hp_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TRIM_W-1:0] val_q;
  logic [CODE_W-1:0] code_q;
  logic              err_q;

  logic              accept;
  logic              legal;
  logic              start;
  logic              tick;
  logic              shift_done;
  logic              store_wr;
  logic [WORD_W-1:0] word;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign legal     = (req_index < IDX_W'(NUM_IDX));
  assign start     = accept && legal;
  assign word      = {req_index[CH_BITS-1:0], req_value};
  assign store_wr  = (state_q == ST_LOAD) && tick;
  assign load_code = (state_q == ST_LOAD) ? code_q : '0;
  assign err_flag  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hp_q    <= '0;
      idx_q   <= '0;
      val_q   <= '0;
      code_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            hp_q    <= half_period;
            idx_q   <= req_index;
            val_q   <= req_value;
            code_q  <= CODE_W'(req_index >> CH_BITS) + CODE_W'(1);
          end
        end
        ST_SHIFT: if (shift_done) state_q <= ST_LOAD;
        ST_LOAD:  if (tick)       state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end

  trim_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q != ST_IDLE),
    .limit (hp_q),
    .tick  (tick)
  );

  trim_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .word_in (word),
    .tick    (tick),
    .sdata   (ser_data),
    .sclk    (ser_clk),
    .done    (shift_done)
  );

  trim_store #(.NUM_IDX(NUM_IDX), .IDX_W(IDX_W), .DATA_W(TRIM_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_wr),
    .wr_idx  (idx_q),
    .wr_data (val_q),
    .rd_idx  (rb_index),
    .rd_data (rb_value)
  );

  // R1: ready comes back only at the end of a load window
  assert_ready_after_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(load_code) != '0));

  // R5: while a code is driven the serial lines are quiet, and the code names a real converter
  assert_quiet_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_code != '0) |-> (!ser_clk && !ser_data && load_code <= CODE_W'(NUM_CONV)));

  // R6: no latch code while the shift clock is high
  assert_no_code_clocking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> (load_code == '0));

  // R7: a rejection leaves the block idle
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (req_ready && !ser_clk));

  // R8: the readback write is followed by the code returning to zero
  assert_write_then_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    store_wr |=> (load_code == '0));
endmodule

// File: tb/test_trim_loader.sv
`timescale 1ns/1ps
module test_trim_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_period = 8'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [4:0] req_index = 5'd0;
  logic [7:0] req_value = 8'd0;
  logic       ser_data;
  logic       ser_clk;
  logic [1:0] load_code;
  logic       err_flag;
  logic [4:0] rb_index = 5'd0;
  logic [7:0] rb_value;

  int errors = 0;
  int checks = 0;

  // bench model of the readback entries
  int model [21];

  // serial monitor state
  logic        p_clk = 1'b0;
  logic        p_data = 1'b0;
  logic [1:0]  p_code = 2'd0;
  logic [10:0] sh = '0;
  int          nb = 0;
  int          fc = 0;
  int          cc = 0;
  int          ccyc = 0;
  int          viol = 0;
  int          fr [16];
  int          cl [16];

  always #2 clk = ~clk;

  trim_loader i_trim_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_period (half_period),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_index   (req_index),
    .req_value   (req_value),
    .ser_data    (ser_data),
    .ser_clk     (ser_clk),
    .load_code   (load_code),
    .err_flag    (err_flag),
    .rb_index    (rb_index),
    .rb_value    (rb_value)
  );

  always @(negedge clk) begin
    if (ser_clk && !p_clk) begin
      sh = {sh[9:0], ser_data};
      nb = nb + 1;
      if (nb == 11) begin
        if (fc < 16) fr[fc] = int'(sh);
        fc = fc + 1;
        nb = 0;
      end
    end
    if (ser_clk && p_clk && (ser_data != p_data)) viol = viol + 1;
    if (load_code != 2'd0) begin
      ccyc = ccyc + 1;
      if (p_code == 2'd0) begin
        if (cc < 16) cl[cc] = int'(load_code);
        cc = cc + 1;
      end
    end
    p_clk  = ser_clk;
    p_data = ser_data;
    p_code = load_code;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int word_of(input int idx, input int val);
    return ((idx & 7) << 8) | (val & 8'hff);
  endfunction

  function automatic int code_of(input int idx);
    return (idx >> 3) + 1;
  endfunction

  // R10: reset state
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after reset", int'(req_ready), 1);
    chk(ser_clk == 1'b0, "R10", "ser_clk", int'(ser_clk), 0);
    chk(ser_data == 1'b0, "R10", "ser_data", int'(ser_data), 0);
    chk(load_code == 2'd0, "R10", "load_code", int'(load_code), 0);
    chk(err_flag == 1'b0, "R10", "err_flag", int'(err_flag), 0);
    for (int i = 0; i < 21; i++) begin
      rb_index = 5'(i);
      #1;
      chk(rb_value == 8'd0, "R10", "readback entry zero", int'(rb_value), 0);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R8 R9: one legal request, divider changed after acceptance
  task automatic t_send(input int idx, input int val, input int d);
    int f0, c0, busy, rbd, old;
    old = model[idx];
    f0 = fc;
    c0 = cc;
    @(negedge clk);
    half_period = 8'(d);
    req_index   = 5'(idx);
    req_value   = 8'(val);
    req_valid   = 1'b1;
    rb_index    = 5'(idx);
    @(posedge clk);
    #1;
    req_valid   = 1'b0;
    half_period = 8'(d ^ 3);
    ccyc = 0;
    viol = 0;
    busy = 0;
    rbd  = old;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      busy++;
      if (load_code != 2'd0) rbd = int'(rb_value);
      if (ser_clk && load_code != 2'd0)
        chk(1'b0, "R6", "code while clock high", int'(load_code), 0);
    end
    chk(busy == 23 * (d + 1), "R1", "busy cycles", busy, 23 * (d + 1));
    chk(fc - f0 == 1, "R2", "frame count", fc - f0, 1);
    chk(nb == 0, "R2", "leftover bits", nb, 0);
    chk(fr[(fc - 1) % 16] == word_of(idx, val), "R2", "serial word",
        fr[(fc - 1) % 16], word_of(idx, val));
    chk(viol == 0, "R3", "data moved while clock high", viol, 0);
    chk(ccyc == d + 1, "R4", "load window length", ccyc, d + 1);
    chk(cc - c0 == 1, "R5", "load pulses", cc - c0, 1);
    chk(cl[(cc - 1) % 16] == code_of(idx), "R5", "load code",
        cl[(cc - 1) % 16], code_of(idx));
    chk(load_code == 2'd0, "R6", "code back to zero", int'(load_code), 0);
    chk(rbd == old, "R8", "readback during load", rbd, old);
    model[idx] = val;
    chk(int'(rb_value) == val, "R9", "readback after load", int'(rb_value), val);
  endtask

  // R7 R9: out-of-range index rejected
  task automatic t_reject(input int idx, input int val);
    int f0, c0;
    f0 = fc;
    c0 = cc;
    @(negedge clk);
    half_period = 8'd0;
    req_index   = 5'(idx);
    req_value   = 8'(val);
    req_valid   = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(err_flag == 1'b1, "R7", "err pulse", int'(err_flag), 1);
    chk(req_ready == 1'b1, "R7", "ready stays high", int'(req_ready), 1);
    @(negedge clk);
    chk(err_flag == 1'b0, "R7", "err one cycle", int'(err_flag), 0);
    repeat (30) @(negedge clk);
    chk(fc == f0 && nb == 0, "R7", "no serial activity", fc - f0 + nb, 0);
    chk(cc == c0, "R7", "no load code", cc - c0, 0);
    for (int i = 0; i < 21; i++) begin
      rb_index = 5'(i);
      #1;
      chk(int'(rb_value) == model[i], "R7", "readback untouched",
          int'(rb_value), model[i]);
    end
    rb_index = 5'(idx);
    #1;
    chk(rb_value == 8'd0, "R9", "out-of-range readback", int'(rb_value), 0);
  endtask

  // R1: second request held on the inputs waits for the first to finish
  task automatic t_backpressure();
    int f0, c0, busy;
    f0 = fc;
    c0 = cc;
    @(negedge clk);
    half_period = 8'd1;
    req_index   = 5'd3;
    req_value   = 8'h5A;
    req_valid   = 1'b1;
    @(posedge clk);
    #1;
    req_index = 5'd18;
    req_value = 8'hC3;
    busy = 0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
      busy++;
    end
    chk(busy == 46, "R1", "first busy length", busy, 46);
    chk(fc - f0 == 1, "R1", "held request not started early", fc - f0, 1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    chk(fc - f0 == 2, "R1", "frames sent", fc - f0, 2);
    chk(fr[f0 % 16] == word_of(3, 8'h5A), "R2", "first word",
        fr[f0 % 16], word_of(3, 8'h5A));
    chk(fr[(f0 + 1) % 16] == word_of(18, 8'hC3), "R2", "held word",
        fr[(f0 + 1) % 16], word_of(18, 8'hC3));
    chk(cl[c0 % 16] == 1 && cl[(c0 + 1) % 16] == 3, "R5", "code order",
        cl[c0 % 16] * 10 + cl[(c0 + 1) % 16], 13);
    model[3]  = 8'h5A;
    model[18] = 8'hC3;
    rb_index = 5'd3;
    #1;
    chk(int'(rb_value) == model[3], "R8", "first readback", int'(rb_value), model[3]);
    rb_index = 5'd18;
    #1;
    chk(int'(rb_value) == model[18], "R8", "held readback", int'(rb_value), model[18]);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 21; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    t_reset();
    t_send(0, 8'hA5, 0);
    t_send(12, 8'h3C, 2);
    t_send(20, 8'hFF, 1);
    t_send(7, 8'h00, 3);
    t_send(13, 8'h81, 0);
    t_send(0, 8'h5E, 1);
    t_reject(21, 8'h55);
    t_reject(31, 8'hAA);
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule